// File: doc/BRIEF.md
# Selectable PRBS Generator and Checker

This block is a diagnostic pattern engine for a line interface. The transmit half produces a pseudo-random bit stream as one parallel word per clock. The receive half checks a stream of the same form. Each half picks its own pattern length from four choices, its own polarity and its own enable. The transmit half can corrupt its output on purpose, either one bit or a whole word. Each kind of corruption can be applied once or held for as long as a control stays high. This lets software test the error-detection path from end to end.

The receive half synchronises itself to whatever pattern arrives. It seeds its shift register from the incoming bits. It raises a lock flag once the stream has followed the selected recurrence for long enough. While locked, it counts every bit that differs from its own prediction. A run of badly errored words drops the lock, and the checker then reseeds. The bit-error total is kept in a saturating counter that clears when it is read.

Top module: `prbs_diag`

## Requirements
- R1: After reset, tx_data is zero, rx_locked is low and err_count is zero. The generator history starts as all ones, so every previous output bit counts as 1.
- R2: Pattern select codes are 0 = x^7+x^6+1, 1 = x^15+x^14+1, 2 = x^23+x^18+1 and 3 = x^31+x^28+1. For length N and tap T, each new bit is o[n] = o[n-N] xor o[n-T]. If the last N bits were all zero, the new bit is 1 instead. On each clock edge where tx_en is high, the next W bits are registered onto tx_data, with the earliest bit on bit W-1.
- R3: When tx_inv is high, every bit of tx_data is the complement of the R2 pattern bit.
- R4: On an edge where tx_en is low, tx_data becomes zero and the pattern does not advance. The sequence resumes where it stopped once tx_en returns high.
- R5: A bit error inverts bit 0 of the outgoing word. A pulse on inj_bit_once corrupts exactly one word: the one registered at that edge if tx_en is high, otherwise the next word registered with tx_en high. inj_bit_cont corrupts every word registered while it is held.
- R6: A word error inverts all W bits of the outgoing word, from inj_word_once (same one-shot rule as R5) or inj_word_cont (held). When a word error and a bit error fall on the same word, the word error alone applies.
- R7: rx_data is first complemented when rx_inv is high and then read earliest bit first (bit W-1). The checker locks after 32 consecutive bits that obey the R2 recurrence selected by rx_sel. A stream of the opposite polarity never locks.
- R8: While locked, each received bit that differs from the checker's free-running prediction adds 1 to err_count. While unlocked, nothing is counted.
- R9: Lock is tracked in 16-word windows that start at lock. The 8th errored word within a window clears rx_locked on that edge. The checker then reseeds from the incoming data and relocks on clean data.
- R10: err_count saturates at 2^CNT_W-1. On an edge with err_rd high, it loads only that edge's new error bits, which is zero for a clean or ignored word.
- R11: On an edge with rx_en low, rx_data is ignored: no errors are counted and neither rx_locked nor the checker state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Generator enable |
| tx_sel | input | 2 | Generator pattern select (R2 codes) |
| tx_inv | input | 1 | Generator polarity invert |
| inj_bit_once | input | 1 | Single-bit error, one word |
| inj_bit_cont | input | 1 | Single-bit error on every word while high |
| inj_word_once | input | 1 | Whole-word error, one word |
| inj_word_cont | input | 1 | Whole-word error on every word while high |
| tx_data | output | W | Generated word, earliest bit on W-1 |
| rx_en | input | 1 | Checker enable; rx_data is valid when high |
| rx_sel | input | 2 | Checker pattern select (R2 codes) |
| rx_inv | input | 1 | Checker polarity invert |
| rx_data | input | W | Received word, earliest bit on W-1 |
| rx_locked | output | 1 | Checker lock flag |
| err_rd | input | 1 | Read strobe that clears the error counter |
| err_count | output | CNT_W | Saturating bit-error count |

## Verification
Some properties can be checked on every cycle. A disabled generator drives zero. An ignored receive word changes neither the count nor the lock. An unlocked checker never counts. The counter only moves upward between reads, and a read with the checker idle clears it. Lock can only fall on an enabled word.

Other behaviours need the bench's scenarios. These are the exact pattern bits for every length and polarity, and the one-shot and held injection counts. They also include a one-shot request held across a disabled stretch, and word-over-bit priority. The rest are lock acquisition and its loss under sustained errors, the polarity mismatch that never locks, and saturation of a narrowed counter.

// File: rtl/prbs_diag_pkg.sv
package prbs_diag_pkg;

  typedef enum logic [1:0] {
    PAT_L7  = 2'd0,
    PAT_L15 = 2'd1,
    PAT_L23 = 2'd2,
    PAT_L31 = 2'd3
  } pat_sel_e;

  localparam int HIST_W = 31;

  // Feedback bit for a history whose bit 0 is the most recent bit.
  function automatic logic lfsr_fb(input logic [HIST_W-1:0] h, input pat_sel_e sel);
    int n;
    int t;
    logic [HIST_W-1:0] m;
    case (sel)
      PAT_L7:  begin n = 7;  t = 6;  end
      PAT_L15: begin n = 15; t = 14; end
      PAT_L23: begin n = 23; t = 18; end
      default: begin n = 31; t = 28; end
    endcase
    m = HIST_W'((32'd1 << n) - 32'd1);
    if ((h & m) == '0) return 1'b1;
    return h[n-1] ^ h[t-1];
  endfunction

endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_diag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  pat_sel_e     sel,
  input  logic         inv,
  input  logic         bit_once,
  input  logic         bit_cont,
  input  logic         word_once,
  input  logic         word_cont,
  output logic [W-1:0] data_o
);

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [W-1:0]      data_q, data_d;
  logic              pend_bit_q, pend_bit_d;
  logic              pend_word_q, pend_word_d;

  always_comb begin
    logic [HIST_W-1:0] h;
    logic [W-1:0]      pat;
    logic              fb;
    logic              bit_req;
    logic              word_req;
    h = hist_q;
    pat = '0;
    for (int i = 0; i < W; i++) begin
      fb = lfsr_fb(h, sel);
      pat[W-1-i] = fb;
      h = {h[HIST_W-2:0], fb};
    end
    bit_req  = bit_once | bit_cont | pend_bit_q;
    word_req = word_once | word_cont | pend_word_q;
    pat = pat ^ {W{inv}};
    if (word_req)     pat = ~pat;
    else if (bit_req) pat[0] = ~pat[0];

    hist_d      = hist_q;
    data_d      = '0;
    pend_bit_d  = pend_bit_q | bit_once;
    pend_word_d = pend_word_q | word_once;
    if (en) begin
      hist_d      = h;
      data_d      = pat;
      pend_bit_d  = 1'b0;
      pend_word_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q      <= '1;
      data_q      <= '0;
      pend_bit_q  <= 1'b0;
      pend_word_q <= 1'b0;
    end else begin
      hist_q      <= hist_d;
      data_q      <= data_d;
      pend_bit_q  <= pend_bit_d;
      pend_word_q <= pend_word_d;
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_diag_pkg::*;
#(
  parameter int W          = 32,
  parameter int LOCK_BITS  = 32,
  parameter int WIN_WORDS  = 16,
  parameter int DROP_WORDS = 8,
  localparam int EW = $clog2(W + 1),
  localparam int RW = $clog2(LOCK_BITS + 1),
  localparam int WW = $clog2(WIN_WORDS),
  localparam int BW = $clog2(DROP_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  pat_sel_e      sel,
  input  logic          inv,
  input  logic [W-1:0]  data_i,
  output logic          locked_o,
  output logic [EW-1:0] err_inc_o
);

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [RW-1:0]     run_q, run_d;
  logic              lock_q, lock_d;
  logic [WW-1:0]     win_q, win_d;
  logic [BW-1:0]     bad_q, bad_d;
  logic [EW-1:0]     nerr;

  always_comb begin
    logic [HIST_W-1:0] h;
    logic [RW-1:0]     run;
    logic [BW-1:0]     bad_n;
    logic              rb;
    logic              pb;
    h    = hist_q;
    run  = run_q;
    nerr = '0;
    for (int i = 0; i < W; i++) begin
      rb = data_i[W-1-i] ^ inv;
      pb = lfsr_fb(h, sel);
      if (lock_q) begin
        if (pb != rb) nerr = nerr + EW'(1);
        h = {h[HIST_W-2:0], pb};
      end else begin
        if (pb != rb)                    run = '0;
        else if (run < RW'(LOCK_BITS))   run = run + RW'(1);
        h = {h[HIST_W-2:0], rb};
      end
    end

    hist_d = hist_q;
    run_d  = run_q;
    lock_d = lock_q;
    win_d  = win_q;
    bad_d  = bad_q;
    bad_n  = bad_q + BW'(nerr != '0);
    if (en) begin
      hist_d = h;
      if (lock_q) begin
        if (bad_n >= BW'(DROP_WORDS)) begin
          lock_d = 1'b0;
          win_d  = '0;
          bad_d  = '0;
          run_d  = '0;
        end else if (win_q == WW'(WIN_WORDS - 1)) begin
          win_d = '0;
          bad_d = '0;
        end else begin
          win_d = win_q + WW'(1);
          bad_d = bad_n;
        end
      end else if (run >= RW'(LOCK_BITS)) begin
        lock_d = 1'b1;
        run_d  = '0;
        win_d  = '0;
        bad_d  = '0;
      end else begin
        run_d = run;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      run_q  <= '0;
      lock_q <= 1'b0;
      win_q  <= '0;
      bad_q  <= '0;
    end else begin
      hist_q <= hist_d;
      run_q  <= run_d;
      lock_q <= lock_d;
      win_q  <= win_d;
      bad_q  <= bad_d;
    end
  end

  assign locked_o  = lock_q;
  assign err_inc_o = (en && lock_q) ? nerr : '0;

endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, (clr ? {CNT_W{1'b0}} : cnt_q)} + (CNT_W+1)'(inc);
    cnt_d = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/prbs_diag.sv
module prbs_diag
  import prbs_diag_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 32,
  localparam int EW   = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [1:0]       tx_sel,
  input  logic             tx_inv,
  input  logic             inj_bit_once,
  input  logic             inj_bit_cont,
  input  logic             inj_word_once,
  input  logic             inj_word_cont,
  output logic [W-1:0]     tx_data,
  input  logic             rx_en,
  input  logic [1:0]       rx_sel,
  input  logic             rx_inv,
  input  logic [W-1:0]     rx_data,
  output logic             rx_locked,
  input  logic             err_rd,
  output logic [CNT_W-1:0] err_count
);

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic [EW-1:0] err_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  prbs_gen #(.W(W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (tx_en),
    .sel       (pat_sel_e'(tx_sel)),
    .inv       (tx_inv),
    .bit_once  (inj_bit_once),
    .bit_cont  (inj_bit_cont),
    .word_once (inj_word_once),
    .word_cont (inj_word_cont),
    .data_o    (tx_data)
  );

  prbs_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (rx_en),
    .sel       (pat_sel_e'(rx_sel)),
    .inv       (rx_inv),
    .data_i    (rx_data),
    .locked_o  (rx_locked),
    .err_inc_o (err_inc)
  );

  prbs_err_cnt #(.CNT_W(CNT_W), .INC_W(EW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc     (err_inc),
    .clr     (err_rd),
    .count_o (err_count)
  );

endmodule

// File: rtl/prbs_diag_sva.sv
module prbs_diag_sva #(
  parameter int W     = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic [W-1:0]     tx_data,
  input logic             rx_en,
  input logic             rx_locked,
  input logic             err_rd,
  input logic [CNT_W-1:0] err_count
);

  AST_TX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_data == '0); // R4

  AST_RX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !err_rd) |=> ($stable(err_count) && $stable(rx_locked))); // R11

  AST_UNLOCKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_locked && !err_rd) |=> $stable(err_count)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !err_rd |=> err_count >= $past(err_count)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !rx_en) |=> err_count == '0); // R10

  AST_LOCK_FALL_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_locked) |-> $past(rx_en)); // R9

endmodule

bind prbs_diag prbs_diag_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_en     (tx_en),
  .tx_data   (tx_data),
  .rx_en     (rx_en),
  .rx_locked (rx_locked),
  .err_rd    (err_rd),
  .err_count (err_count)
);

// File: tb/prbs_diag_tb.sv
module prbs_diag_tb;
  localparam int W     = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             tx_en, tx_inv, rx_en, rx_inv, err_rd;
  logic [1:0]       tx_sel, rx_sel;
  logic             inj_bit_once, inj_bit_cont, inj_word_once, inj_word_cont;
  logic [W-1:0]     tx_data;
  logic [W-1:0]     rx_data;
  logic             rx_locked;
  logic [CNT_W-1:0] err_count;

  assign rx_data = tx_data;

  prbs_diag #(.W(W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_sel(tx_sel), .tx_inv(tx_inv),
    .inj_bit_once(inj_bit_once), .inj_bit_cont(inj_bit_cont),
    .inj_word_once(inj_word_once), .inj_word_cont(inj_word_cont),
    .tx_data(tx_data), .rx_en(rx_en), .rx_sel(rx_sel), .rx_inv(rx_inv),
    .rx_data(rx_data), .rx_locked(rx_locked), .err_rd(err_rd), .err_count(err_count)
  );

  int n_chk = 0;
  int n_err = 0;
  bit m_hist [31];
  bit pb, pw;
  logic tx_en_last;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference pattern: o[n] = o[n-N] ^ o[n-T], m_hist[k] is o[n-1-k].
  function automatic bit model_bit(input int sel);
    int n, t;
    bit b, allz;
    case (sel)
      0: begin n = 7;  t = 6;  end
      1: begin n = 15; t = 14; end
      2: begin n = 23; t = 18; end
      default: begin n = 31; t = 28; end
    endcase
    allz = 1'b1;
    for (int k = 0; k < n; k++) if (m_hist[k]) allz = 1'b0;
    b = allz ? 1'b1 : (m_hist[n-1] ^ m_hist[t-1]);
    for (int k = 30; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = b;
    return b;
  endfunction

  function automatic logic [W-1:0] model_word(input int sel);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[W-1-i] = model_bit(sel);
    return w;
  endfunction

  task automatic tick();
    rx_en = tx_en_last;
    @(posedge clk);
    tx_en_last = tx_en;
    @(negedge clk);
  endtask

  task automatic step(input bit bo, input bit bc, input bit wo, input bit wc, input string req);
    logic [W-1:0] e;
    if (tx_en) begin
      e = model_word(int'(tx_sel)) ^ {W{tx_inv}};
      if (wo || wc || pw)      e = ~e;
      else if (bo || bc || pb) e[0] = ~e[0];
      pb = 1'b0;
      pw = 1'b0;
    end else begin
      e = '0;
      pb = pb | bo;
      pw = pw | wo;
    end
    inj_bit_once = bo; inj_bit_cont = bc; inj_word_once = wo; inj_word_cont = wc;
    tick();
    inj_bit_once = 1'b0; inj_bit_cont = 1'b0; inj_word_once = 1'b0; inj_word_cont = 1'b0;
    chk(tx_data === e, req, 64'(tx_data), 64'(e));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_en = 1'b0; rx_en = 1'b0; err_rd = 1'b0; tx_en_last = 1'b0;
    inj_bit_once = 1'b0; inj_bit_cont = 1'b0; inj_word_once = 1'b0; inj_word_cont = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    for (int k = 0; k < 31; k++) m_hist[k] = 1'b1;
    pb = 1'b0; pw = 1'b0;
    chk(tx_data === '0, "R1 tx_data", 64'(tx_data), 64'd0);
    chk(rx_locked === 1'b0, "R1 rx_locked", 64'(rx_locked), 64'd0);
    chk(err_count === '0, "R1 err_count", 64'(err_count), 64'd0);
  endtask

  task automatic settle_read(input int exp, input string req);
    repeat (20) step(0, 0, 0, 0, req);
    chk(err_count === CNT_W'(exp), req, 64'(err_count), 64'(exp));
    err_rd = 1'b1;
    step(0, 0, 0, 0, req);
    err_rd = 1'b0;
    chk(err_count === '0, "R10 clear on read", 64'(err_count), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_sel = 2'd0; rx_sel = 2'd0; tx_inv = 1'b0; rx_inv = 1'b0;

    // R2 / R3 / R7 / R8: every length in both polarities, looped back
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        tx_sel = 2'(s); rx_sel = 2'(s); tx_inv = v[0]; rx_inv = v[0];
        do_reset();
        tx_en = 1'b1;
        repeat (40) step(0, 0, 0, 0, v ? "R3 inverted word" : "R2 pattern word");
        chk(rx_locked === 1'b1, "R7 lock acquired", 64'(rx_locked), 64'd1);
        chk(err_count === '0, "R8 clean stream count", 64'(err_count), 64'd0);
      end
    end

    // R7: opposite polarity never locks, R8: nothing counted while unlocked
    tx_sel = 2'd0; rx_sel = 2'd0; tx_inv = 1'b1; rx_inv = 1'b0;
    do_reset();
    tx_en = 1'b1;
    repeat (40) step(0, 0, 0, 0, "R3 inverted word");
    chk(rx_locked === 1'b0, "R7 polarity mismatch", 64'(rx_locked), 64'd0);
    chk(err_count === '0, "R8 unlocked count", 64'(err_count), 64'd0);

    // Injection scenarios on the 15-bit pattern
    tx_sel = 2'd1; rx_sel = 2'd1; tx_inv = 1'b0; rx_inv = 1'b0;
    do_reset();
    tx_en = 1'b1;
    repeat (40) step(0, 0, 0, 0, "R2 pattern word");
    chk(rx_locked === 1'b1, "R7 lock acquired", 64'(rx_locked), 64'd1);

    step(1, 0, 0, 0, "R5 bit once");
    settle_read(1, "R5 bit once count");
    repeat (3) step(0, 1, 0, 0, "R5 bit held");
    settle_read(3, "R5 bit held count");
    step(0, 0, 1, 0, "R6 word once");
    settle_read(W, "R6 word once count");
    repeat (2) step(0, 0, 0, 1, "R6 word held");
    settle_read(2 * W, "R6 word held count");
    step(1, 0, 1, 0, "R6 word over bit");
    settle_read(W, "R6 priority count");

    // R4 / R11 / R5: pause with a pending one-shot bit error
    tx_en = 1'b0;
    step(1, 0, 0, 0, "R4 idle zero");
    repeat (3) step(0, 0, 0, 0, "R4 idle zero");
    tx_en = 1'b1;
    step(0, 0, 0, 0, "R5 pending bit applied");
    chk(rx_locked === 1'b1, "R11 lock held across pause", 64'(rx_locked), 64'd1);
    settle_read(1, "R11 idle words not counted");

    // R9: seven errored words keep lock
    repeat (7) step(0, 0, 0, 1, "R6 word held");
    repeat (20) step(0, 0, 0, 0, "R2 pattern word");
    chk(rx_locked === 1'b1, "R9 seven errored words", 64'(rx_locked), 64'd1);
    err_rd = 1'b1; step(0, 0, 0, 0, "R10 read"); err_rd = 1'b0;

    // R9: sustained errors drop lock, clean data relocks
    repeat (16) step(0, 1, 0, 0, "R5 bit held");
    step(0, 0, 0, 0, "R2 pattern word");
    chk(rx_locked === 1'b0, "R9 lock dropped", 64'(rx_locked), 64'd0);
    repeat (12) step(0, 0, 0, 0, "R2 pattern word");
    chk(rx_locked === 1'b1, "R9 relock", 64'(rx_locked), 64'd1);
    err_rd = 1'b1; step(0, 0, 0, 0, "R10 read"); err_rd = 1'b0;
    chk(err_count === '0, "R10 clear on read", 64'(err_count), 64'd0);

    // R10: saturation, 9 bursts of 4 fully inverted words = 288 bits
    for (int b = 0; b < 9; b++) begin
      repeat (4) step(0, 0, 0, 1, "R6 word held");
      repeat (20) step(0, 0, 0, 0, "R2 pattern word");
    end
    chk(err_count === {CNT_W{1'b1}}, "R10 saturation", 64'(err_count), 64'(255));
    chk(rx_locked === 1'b1, "R9 sparse errors keep lock", 64'(rx_locked), 64'd1);
    err_rd = 1'b1; step(0, 0, 0, 0, "R10 read"); err_rd = 1'b0;
    chk(err_count === '0, "R10 clear after saturation", 64'(err_count), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule